// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver

This block recovers bytes from an asynchronous serial line that carries frames of one low start bit, eight data bits and one high stop bit, with no parity. The line is first passed through a two-flop synchronizer. The block then samples it at three kinds of interval, each counted in clock cycles and each set by a parameter. While idle, it polls the line at a short scan interval. After it sees a start bit, it waits a longer first-sample delay, by default one and a half bit periods, so that the first data sample lands near the middle of the first data bit. After that, it samples once per bit period.

A ten-value state counter tracks the frame. Value 9 means idle, value 0 means a start bit has been seen, and values 1 to 8 follow each later sample. Data samples shift into bit 0 of the byte register and move the older bits up, so the first bit received ends in bit 7. The byte is therefore assembled MSB first, which is the order the transmitter sends it in. Entering state 8 raises a one-cycle byte-valid strobe. The stop sample that follows returns the counter to idle and updates a framing-error flag.

Top module: `serial_byte_rx`

## Requirements
- R1: After reset, the state code is 9, the sampled bit is 1, the byte is 8'h00, and both byte-valid and the framing error are 0.
- R2: While the synchronized line stays high, the state code stays 9 and byte-valid stays 0.
- R3: When an idle scan sample is low, the state becomes 0 and the sampled bit becomes 0. This happens 3 to SCAN_CYCLES+2 cycles after the line falls, which includes the two synchronizer stages.
- R4: The state stays 0 for exactly FIRST_CYCLES cycles before the first data sample moves it to 1.
- R5: Each of states 1 to 8 lasts exactly BIT_CYCLES cycles. The state goes up by one at each sample, and state 8 returns to 9.
- R6: On entry to state k (1 to 8), the byte equals the previous byte shifted left by k, with the first k received bits in bits k-1..0. On entry to state 8, the byte equals the transmitted byte, with the first bit sent in bit 7.
- R7: The byte holds its value in states 9, 0 and 8, so it survives the stop sample and the next start detection.
- R8: Byte-valid is a pulse exactly one cycle wide. It is raised once per frame, on entry to state 8.
- R9: The framing error is set to 1 when the stop sample is low and cleared to 0 when it is high. It is updated only at the stop sample.
- R10: The sampled-bit output holds the most recent sample: in state 8 it is the last data bit, and after the stop sample it is the stop value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Asynchronous serial input, idle high |
| byte_o | output | 8 | Shift register holding the received byte |
| state_o | output | 4 | Frame state code, 0 to 9, where 9 is idle |
| bit_o | output | 1 | Most recently sampled line value |
| byte_valid_o | output | 1 | One-cycle strobe when a full byte is held |
| frame_err_o | output | 1 | Set when the last stop sample was low |

## Verification
Start detection is due 3 to SCAN_CYCLES+2 cycles after the line falls. Each later state change is due exactly FIRST_CYCLES or BIT_CYCLES cycles after the previous one. To check this, the bench time-stamps every state change at the falling clock edge and compares each measured duration with the parameter value. The byte is snapshotted on entry to every state and compared with a shifted value computed arithmetically. The sweep sends all 256 byte values back to back, each followed by an idle gap, so the register contents left by the previous frame feed into the next frame's expected snapshots. A low stop bit is then driven, and the error flag is read right after the stop sample and again after a following good frame.

// File: rtl/serial_byte_rx.sv
module serial_byte_rx #(
  parameter int BIT_CYCLES   = 16,
  parameter int FIRST_CYCLES = 24,
  parameter int SCAN_CYCLES  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_i,
  output logic [7:0] byte_o,
  output logic [3:0] state_o,
  output logic       bit_o,
  output logic       byte_valid_o,
  output logic       frame_err_o
);
  localparam int MAXA = (FIRST_CYCLES > BIT_CYCLES) ? FIRST_CYCLES : BIT_CYCLES;
  localparam int MAXC = (MAXA > SCAN_CYCLES) ? MAXA : SCAN_CYCLES;
  localparam int TW   = $clog2(MAXC + 1);
  localparam logic [3:0] IDLE = 4'd9;
  localparam logic [3:0] LAST = 4'd8;

  logic [1:0]    sync;
  logic [TW-1:0] tmr;
  logic          tick;
  logic          smp;

  assign tick = (tmr == '0);
  assign smp  = sync[1];

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], line_i};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr          <= TW'(SCAN_CYCLES - 1);
      state_o      <= IDLE;
      bit_o        <= 1'b1;
      byte_o       <= 8'h00;
      byte_valid_o <= 1'b0;
      frame_err_o  <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      if (!tick) begin
        tmr <= tmr - 1'b1;
      end else begin
        bit_o <= smp;
        if (state_o == IDLE) begin
          if (smp) begin
            tmr <= TW'(SCAN_CYCLES - 1);
          end else begin
            state_o <= 4'd0;
            tmr     <= TW'(FIRST_CYCLES - 1);
          end
        end else if (state_o == LAST) begin
          state_o     <= IDLE;
          frame_err_o <= ~smp;
          tmr         <= TW'(SCAN_CYCLES - 1);
        end else begin
          state_o      <= state_o + 4'd1;
          byte_o       <= {byte_o[6:0], smp};
          byte_valid_o <= (state_o == 4'd7);
          tmr          <= TW'(BIT_CYCLES - 1);
        end
      end
    end
  end
endmodule

module serial_byte_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] byte_o,
  input logic [3:0] state_o,
  input logic       bit_o,
  input logic       byte_valid_o
);
  assert_state_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 4'd9);
  assert_idle_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 4'd9 |=> state_o == 4'd9 || (state_o == 4'd0 && !bit_o));
  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state_o < 4'd8 |=> state_o == $past(state_o) || state_o == $past(state_o) + 4'd1);
  assert_last_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 4'd8 |=> state_o == 4'd8 || state_o == 4'd9);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'd9 || state_o == 4'd8) |=> $stable(byte_o));
  assert_valid_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> state_o == 4'd8 && $past(state_o) == 4'd7);
  assert_valid_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |=> !byte_valid_o);
endmodule

bind serial_byte_rx serial_byte_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_o(byte_o), .state_o(state_o),
  .bit_o(bit_o), .byte_valid_o(byte_valid_o)
);

// File: tb/tb_serial_byte_rx.sv
module tb_serial_byte_rx;
  localparam int BITC = 16;
  localparam int FIRSTC = 24;
  localparam int SCANC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_i = 1'b1;
  logic [7:0] byte_o;
  logic [3:0] state_o;
  logic bit_o, byte_valid_o, frame_err_o;

  serial_byte_rx #(.BIT_CYCLES(BITC), .FIRST_CYCLES(FIRSTC), .SCAN_CYCLES(SCANC)) dut (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .byte_o(byte_o), .state_o(state_o),
    .bit_o(bit_o), .byte_valid_o(byte_valid_o), .frame_err_o(frame_err_o)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0;
  int fall_cyc = 0, det_cyc = 0;
  int run = 0, vrun = 0, vmax = 0, vcnt = 0;
  int dur [0:9];
  logic [7:0] snap [0:9];
  logic [3:0] prev_st = 4'd9;
  logic bit_at_valid = 1'b0;
  logic err_at_stop = 1'b0;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (state_o != prev_st) begin
        dur[prev_st] = run;
        run = 1;
        snap[state_o] = byte_o;
        if (state_o == 4'd0) det_cyc = cyc;
        if (state_o == 4'd9) err_at_stop = frame_err_o;
      end else run++;
      prev_st = state_o;
      if (byte_valid_o) begin
        vrun++;
        vcnt++;
        bit_at_valid = bit_o;
        if (vrun > vmax) vmax = vrun;
      end else vrun = 0;
    end
  end

  task automatic hold_line(input logic v, input int n);
    line_i = v;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [7:0] b, input logic stopv);
    @(posedge clk); #1;
    fall_cyc = cyc;
    hold_line(1'b0, BITC);
    for (int i = 7; i >= 0; i--) hold_line(b[i], BITC);
    hold_line(stopv, BITC);
    hold_line(1'b1, 3 * BITC);
  endtask

  initial begin
    logic [7:0] prev;
    int v0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(state_o == 4'd9, "R1 state", state_o, 9);
    chk(bit_o == 1'b1, "R1 bit", bit_o, 1);
    chk(byte_o == 8'h00, "R1 byte", byte_o, 0);
    chk(byte_valid_o == 1'b0, "R1 valid", byte_valid_o, 0);
    chk(frame_err_o == 1'b0, "R1 err", frame_err_o, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      chk(state_o == 4'd9 && !byte_valid_o, "R2 idle", {state_o, byte_valid_o}, 32'h12);
    end
    prev = 8'h00;
    for (int n = 0; n < 256; n++) begin
      logic [7:0] b;
      b = 8'(n ^ 8'h5A);
      v0 = vcnt;
      vmax = 0;
      send(b, 1'b1);
      @(negedge clk);
      chk(det_cyc - fall_cyc >= 3 && det_cyc - fall_cyc <= SCANC + 2, "R3 detect latency",
          det_cyc - fall_cyc, 3);
      chk(snap[0] == prev, "R7 byte held at start", snap[0], prev);
      chk(dur[0] == FIRSTC, "R4 first delay", dur[0], FIRSTC);
      for (int k = 1; k <= 8; k++) begin
        logic [15:0] w;
        w = {8'h00, prev} << k;
        w = w | (16'(b) >> (8 - k));
        chk(dur[k] == BITC, "R5 bit period", dur[k], BITC);
        chk(snap[k] == w[7:0], "R6 shift snapshot", snap[k], w[7:0]);
      end
      chk(snap[8] == b, "R6 full byte", snap[8], b);
      chk(state_o == 4'd9, "R5 back to idle", state_o, 9);
      chk(byte_o == b, "R7 byte held in idle", byte_o, b);
      chk(vcnt == v0 + 1 && vmax == 1, "R8 valid pulse", {vcnt - v0, vmax}, 32'h1_0001);
      chk(bit_at_valid == b[0], "R10 last data bit", bit_at_valid, b[0]);
      chk(bit_o == 1'b1, "R10 stop value", bit_o, 1);
      chk(err_at_stop == 1'b0, "R9 good stop", err_at_stop, 0);
      prev = b;
    end
    send(8'hA5, 1'b0);
    chk(err_at_stop == 1'b1, "R9 low stop sets error", err_at_stop, 1);
    hold_line(1'b1, 12 * BITC);
    send(8'h3C, 1'b1);
    @(negedge clk);
    chk(err_at_stop == 1'b0 && frame_err_o == 1'b0, "R9 good stop clears", frame_err_o, 0);
    chk(byte_o == 8'h3C, "R6 byte after error", byte_o, 8'h3C);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule